// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block sits on the host side of a differential sampling converter with a three-wire serial link. The link has a start-of-conversion strobe, a serial clock and a serial data line. The controller derives the serial clock from the system clock by a programmable half-period divider. For each convert command it raises the start strobe, then runs a frame of 18 serial clock cycles: 16 cycles move the result and 2 give the converter its acquisition time. It shifts in the two's-complement result, sign-extends it to 16 bits and presents it with a one-cycle valid strobe.

Each word that comes out belongs to the conversion started in the frame before. For this reason the first word after reset, and the first after a wake-up, is marked stale with a flag.

Power-down needs no extra wire. With the serial clock held low, two start pulses put the converter into the light power-down state and four or more put it into the deep one. A single serial clock pulse wakes it. After the deep state, the controller holds busy for a parameterised settle time so that the reference can recover before conversions resume.

Top module: `sadc_reader`

## Requirements
- R1: Out of reset, busy, adc_trig, ser_clk and smp_valid are all low.
- R2: A convert command (cmd_op = 2'b00) produces exactly one adc_trig pulse followed by exactly 18 rising edges of ser_clk. ser_clk ends low, and busy then returns low.
- R3: adc_trig is high for SCK_HALF system cycles with ser_clk low, and it falls as the first ser_clk rising edge occurs. adc_trig and ser_clk are never high together. Each ser_clk high phase lasts SCK_HALF system cycles.
- R4: With RES_BITS = 14, ser_din is sampled at ser_clk rising edges 3 to 16 (counting from 1 after the trigger), MSB first. The word is sign-extended from bit 13 to 16 bits on smp_data, with a single-cycle smp_valid pulse per frame.
- R5: With RES_BITS = 12, data is taken at rising edges 3 to 14, sign-extended from bit 11. The bits at edges 15 to 18 have no effect on smp_data.
- R6: smp_first is 1 on the first result after reset or after a wake command, and 0 on every later result.
- R7: The light power-down command (cmd_op = 2'b01) issues exactly 2 adc_trig pulses with no ser_clk edge.
- R8: The deep power-down command (cmd_op = 2'b10) issues exactly PD_SLEEP_PULSES (at least 4) adc_trig pulses with no ser_clk edge.
- R9: While powered down, every command except wake is ignored: no adc_trig pulse, no ser_clk edge, and busy stays low.
- R10: The wake command (cmd_op = 2'b11) issues one ser_clk pulse. After deep power-down, busy stays high for at least SETTLE_CYCLES further cycles. After light power-down, busy is high for no more than 2*SCK_HALF+1 cycles.
- R11: A command presented while busy is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled when not busy |
| cmd_op | input | 2 | 00 convert, 01 light power-down, 10 deep power-down, 11 wake |
| busy | output | 1 | Frame, pulse train or settle wait in progress |
| adc_trig | output | 1 | Start-of-conversion strobe to the converter |
| ser_clk | output | 1 | Serial clock to the converter |
| ser_din | input | 1 | Serial result bit from the converter |
| smp_data | output | 16 | Sign-extended result word |
| smp_valid | output | 1 | One-cycle strobe for smp_data |
| smp_first | output | 1 | Result is stale (first after reset or wake) |

## Verification
On every cycle, the assertions check that the strobe and the serial clock never overlap, that the serial clock moves only on divider ticks, and that the edge count never passes 18. They also check that both lines stay quiet while powered down, that the settle wait is not cut short, and that the valid strobe is a single cycle with the stale mark cleared behind it. Some behaviour only the bench scenarios can show. Those scenarios cover the exact number of edges and pulses per command, the strobe-to-clock lead, the bit positions and sign extension for both word widths, the discarding of trailing bits, the one-frame result lag, commands ignored while busy or asleep, and the length of the wake wait.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    OP_CONV  = 2'd0,
    OP_NAP   = 2'd1,
    OP_SLEEP = 2'd2,
    OP_WAKE  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TRIG,
    ST_RUN,
    ST_PD_HI,
    ST_PD_LO,
    ST_DOWN,
    ST_WK_HI,
    ST_WK_LO,
    ST_SETTLE
  } st_e;

  localparam int FRAME_EDGES     = 18;
  localparam int FIRST_DATA_EDGE = 3;
  localparam int NAP_PULSES      = 2;
  localparam int OUT_W           = 16;
endpackage

// File: rtl/sadc_tick.sv
module sadc_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = en && (cnt_q == CW'(HALF - 1));

  always_comb begin
    if (!en || tick) cnt_n = '0;
    else             cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/sadc_settle.sv
module sadc_settle #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic zero
);
  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] cnt_q, cnt_n;

  assign zero = (cnt_q == '0);

  always_comb begin
    if (start)      cnt_n = TW'(CYCLES);
    else if (!zero) cnt_n = cnt_q - TW'(1);
    else            cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R10
  no_early_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !zero);
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture
  import sadc_pkg::*;
#(
  parameter int RES_BITS = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             cap_last,
  input  logic             din,
  input  logic             mark_stale,
  output logic [OUT_W-1:0] data,
  output logic             valid,
  output logic             first
);
  localparam int EXT = OUT_W - RES_BITS;

  logic [RES_BITS-2:0] sh_q, sh_n;
  logic [OUT_W-1:0]    data_q, data_n;
  logic                valid_q, valid_n;
  logic                first_q, first_n;
  logic                stale_q, stale_n;
  logic [RES_BITS-1:0] word;

  assign word = {sh_q, din};

  always_comb begin
    sh_n    = sh_q;
    data_n  = data_q;
    first_n = first_q;
    stale_n = stale_q;
    valid_n = 1'b0;
    if (cap_en) begin
      sh_n = {sh_q[RES_BITS-3:0], din};
      if (cap_last) begin
        data_n  = {{EXT{word[RES_BITS-1]}}, word};
        valid_n = 1'b1;
        first_n = stale_q;
        stale_n = 1'b0;
      end
    end
    if (mark_stale) stale_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      first_q <= 1'b0;
      stale_q <= 1'b1;
    end else begin
      sh_q    <= sh_n;
      data_q  <= data_n;
      valid_q <= valid_n;
      first_q <= first_n;
      stale_q <= stale_n;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign first = first_q;

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R6
  stale_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !stale_q);
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int RES_BITS        = 14,
  parameter int PD_SLEEP_PULSES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       tick,
  input  logic       tmr_zero,
  output logic       tick_en,
  output logic       tmr_start,
  output logic       cap_en,
  output logic       cap_last,
  output logic       mark_stale,
  output logic       trig,
  output logic       sclk,
  output logic       busy
);
  localparam int LAST_DATA_EDGE = FIRST_DATA_EDGE + RES_BITS - 1;
  localparam int LW             = $clog2(PD_SLEEP_PULSES + 1);

  st_e          st_q, st_n;
  logic         sck_q, sck_n;
  logic         trg_q, trg_n;
  logic [4:0]   edge_q, edge_n, edge_nx;
  logic [LW-1:0] left_q, left_n;
  logic         slp_q, slp_n;
  op_e          op;

  assign op      = op_e'(cmd_op);
  assign edge_nx = edge_q + 5'd1;

  always_comb begin
    st_n       = st_q;
    sck_n      = sck_q;
    trg_n      = trg_q;
    edge_n     = edge_q;
    left_n     = left_q;
    slp_n      = slp_q;
    cap_en     = 1'b0;
    cap_last   = 1'b0;
    tmr_start  = 1'b0;
    mark_stale = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          case (op)
            OP_CONV: begin
              st_n  = ST_TRIG;
              trg_n = 1'b1;
            end
            OP_NAP: begin
              st_n   = ST_PD_HI;
              trg_n  = 1'b1;
              left_n = LW'(NAP_PULSES);
              slp_n  = 1'b0;
            end
            OP_SLEEP: begin
              st_n   = ST_PD_HI;
              trg_n  = 1'b1;
              left_n = LW'(PD_SLEEP_PULSES);
              slp_n  = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_TRIG: begin
        if (tick) begin
          trg_n  = 1'b0;
          sck_n  = 1'b1;
          edge_n = 5'd1;
          st_n   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (tick) begin
          if (sck_q) begin
            sck_n = 1'b0;
            if (edge_q == 5'(FRAME_EDGES)) st_n = ST_IDLE;
          end else begin
            sck_n    = 1'b1;
            edge_n   = edge_nx;
            cap_en   = (edge_nx >= 5'(FIRST_DATA_EDGE)) &&
                       (edge_nx <= 5'(LAST_DATA_EDGE));
            cap_last = (edge_nx == 5'(LAST_DATA_EDGE));
          end
        end
      end
      ST_PD_HI: begin
        if (tick) begin
          trg_n = 1'b0;
          st_n  = ST_PD_LO;
        end
      end
      ST_PD_LO: begin
        if (tick) begin
          if (left_q == LW'(1)) begin
            st_n = ST_DOWN;
          end else begin
            left_n = left_q - LW'(1);
            trg_n  = 1'b1;
            st_n   = ST_PD_HI;
          end
        end
      end
      ST_DOWN: begin
        if (cmd_valid && (op == OP_WAKE)) begin
          st_n       = ST_WK_HI;
          sck_n      = 1'b1;
          mark_stale = 1'b1;
        end
      end
      ST_WK_HI: begin
        if (tick) begin
          sck_n = 1'b0;
          st_n  = ST_WK_LO;
        end
      end
      ST_WK_LO: begin
        if (tick) begin
          if (slp_q) begin
            st_n      = ST_SETTLE;
            tmr_start = 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sck_q  <= 1'b0;
      trg_q  <= 1'b0;
      edge_q <= '0;
      left_q <= '0;
      slp_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      sck_q  <= sck_n;
      trg_q  <= trg_n;
      edge_q <= edge_n;
      left_q <= left_n;
      slp_q  <= slp_n;
    end
  end

  assign tick_en = (st_q == ST_TRIG)  || (st_q == ST_RUN)   ||
                   (st_q == ST_PD_HI) || (st_q == ST_PD_LO) ||
                   (st_q == ST_WK_HI) || (st_q == ST_WK_LO);
  assign busy    = (st_q != ST_IDLE) && (st_q != ST_DOWN);
  assign trig    = trg_q;
  assign sclk    = sck_q;

  // R3
  trig_sclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trg_q && sck_q));
  // R3
  sclk_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !tick) |=> $stable(sck_q));
  // R2
  edge_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q <= 5'(FRAME_EDGES));
  // R9
  down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DOWN) |-> (!trg_q && !sck_q));
  // R10
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SETTLE) && !tmr_zero) |=> (st_q == ST_SETTLE));
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
  import sadc_pkg::*;
#(
  parameter int RES_BITS        = 14,
  parameter int SCK_HALF        = 2,
  parameter int PD_SLEEP_PULSES = 4,
  parameter int SETTLE_CYCLES   = 250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  output logic        busy,
  output logic        adc_trig,
  output logic        ser_clk,
  input  logic        ser_din,
  output logic [15:0] smp_data,
  output logic        smp_valid,
  output logic        smp_first
);
  logic tick, tick_en, tmr_start, tmr_zero;
  logic cap_en, cap_last, mark_stale;

  sadc_tick #(.HALF(SCK_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .tick(tick)
  );

  sadc_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .zero(tmr_zero)
  );

  sadc_seq #(.RES_BITS(RES_BITS), .PD_SLEEP_PULSES(PD_SLEEP_PULSES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .tick(tick), .tmr_zero(tmr_zero), .tick_en(tick_en),
    .tmr_start(tmr_start), .cap_en(cap_en), .cap_last(cap_last),
    .mark_stale(mark_stale), .trig(adc_trig), .sclk(ser_clk), .busy(busy)
  );

  sadc_capture #(.RES_BITS(RES_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_last(cap_last),
    .din(ser_din), .mark_stale(mark_stale), .data(smp_data),
    .valid(smp_valid), .first(smp_first)
  );
endmodule

// File: tb/sadc_reader_tb.sv
module sadc_conv_model #(
  parameter int RES  = 14,
  parameter int HALF = 2
) (
  input  logic        clk,
  input  logic        clr,
  input  logic        trig,
  input  logic        sclk,
  input  logic [15:0] word,
  output logic        sdo,
  output int          rises,
  output int          trigs,
  output int          gap,
  output logic        hp_bad,
  output logic        ovl
);
  logic [15:0] cur, pend;
  int nr, since, hi;
  logic pt, ps, wf;

  initial begin
    cur = '0; pend = '0; nr = 0; sdo = 1'b0;
    rises = 0; trigs = 0; gap = -1; hp_bad = 1'b0; ovl = 1'b0;
    since = 0; hi = 0; pt = 1'b0; ps = 1'b0; wf = 1'b0;
  end

  function automatic logic bitf(input int e);
    if (e >= 3 && e <= RES + 2) return cur[RES + 2 - e];
    return e[0];
  endfunction

  always @(posedge trig) begin
    cur = pend; pend = word; nr = 0; sdo = 1'b1;
  end
  always @(posedge sclk) nr = nr + 1;
  always @(negedge sclk) sdo = bitf(nr + 1);

  always @(negedge clk) begin
    if (clr) begin
      rises = 0; trigs = 0; gap = -1; hp_bad = 1'b0; ovl = 1'b0;
    end else begin
      if (trig && !pt) begin trigs++; since = 0; wf = 1'b1; end
      else since++;
      if (sclk && !ps) begin
        rises++;
        if (wf) begin gap = since; wf = 1'b0; end
      end
      if (sclk) hi++;
      else begin
        if (ps && hi != HALF) hp_bad = 1'b1;
        hi = 0;
      end
      if (trig && sclk) ovl = 1'b1;
    end
    pt = trig; ps = sclk;
  end
endmodule

module sadc_reader_tb;
  localparam int HALF   = 2;
  localparam int SETTLE = 300;

  logic clk, rst_n, cmd_valid, clr;
  logic [1:0] cmd_op;
  logic [15:0] w14, w12;
  logic busy, trg, sck, din14, v14, f14;
  logic busy12, trg12, sck12, din12, v12, f12;
  logic [15:0] d14, d12;
  int r14, t14, g14, r12, t12, g12;
  logic hb14, ov14, hb12, ov12;
  int total, bad, nv14, nv12;
  logic [15:0] q14, q12;
  logic qf14, qf12;
  logic [13:0] p14;
  logic [11:0] p12;
  bit exp_first;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  sadc_reader #(.RES_BITS(14), .SCK_HALF(HALF), .PD_SLEEP_PULSES(4),
                .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .adc_trig(trg), .ser_clk(sck), .ser_din(din14),
    .smp_data(d14), .smp_valid(v14), .smp_first(f14));

  sadc_reader #(.RES_BITS(12), .SCK_HALF(HALF), .PD_SLEEP_PULSES(4),
                .SETTLE_CYCLES(SETTLE)) u_dut12 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy12), .adc_trig(trg12), .ser_clk(sck12), .ser_din(din12),
    .smp_data(d12), .smp_valid(v12), .smp_first(f12));

  sadc_conv_model #(.RES(14), .HALF(HALF)) u_m14 (
    .clk(clk), .clr(clr), .trig(trg), .sclk(sck), .word(w14), .sdo(din14),
    .rises(r14), .trigs(t14), .gap(g14), .hp_bad(hb14), .ovl(ov14));
  sadc_conv_model #(.RES(12), .HALF(HALF)) u_m12 (
    .clk(clk), .clr(clr), .trig(trg12), .sclk(sck12), .word(w12), .sdo(din12),
    .rises(r12), .trigs(t12), .gap(g12), .hp_bad(hb12), .ovl(ov12));

  initial begin nv14 = 0; nv12 = 0; end
  always @(negedge clk) begin
    if (v14) begin nv14++; q14 = d14; qf14 = f14; end
    if (v12) begin nv12++; q12 = d12; qf12 = f12; end
  end

  function automatic logic [15:0] sx14(input logic [13:0] w);
    return {{2{w[13]}}, w};
  endfunction
  function automatic logic [15:0] sx12(input logic [11:0] w);
    return {{4{w[11]}}, w};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, output int blen);
    @(negedge clk) begin cmd_valid = 1'b1; cmd_op = op; end
    @(negedge clk) cmd_valid = 1'b0;
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [13:0] a, input logic [11:0] b, input bit intrude);
    int s14, s12;
    w14 = {2'b00, a};
    w12 = {4'h0, b};
    clear_mon();
    s14 = nv14; s12 = nv12;
    @(negedge clk) begin cmd_valid = 1'b1; cmd_op = 2'b00; end
    @(negedge clk) cmd_valid = 1'b0;
    if (intrude) begin
      repeat (6) @(negedge clk);
      // R11: light power-down request while a frame runs
      cmd_valid = 1'b1; cmd_op = 2'b01;
      @(negedge clk) cmd_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(r14 == 18, "R2 sclk edges 14b", r14, 18);
    chk(r12 == 18, "R2 sclk edges 12b", r12, 18);
    chk(t14 == 1, intrude ? "R11 trig count" : "R2 trig count", t14, 1);
    chk(g14 == HALF, "R3 trig lead", g14, HALF);
    chk(!hb14 && !ov14, "R3 sclk half period / overlap", {hb14, ov14}, 0);
    chk(nv14 - s14 == 1, "R4 valid count", nv14 - s14, 1);
    chk(nv12 - s12 == 1, "R5 valid count", nv12 - s12, 1);
    chk(qf14 == exp_first, "R6 first flag 14b", qf14, exp_first);
    chk(qf12 == exp_first, "R6 first flag 12b", qf12, exp_first);
    if (!exp_first) begin
      chk(q14 == sx14(p14), "R4 data 14b", q14, sx14(p14));
      chk(q12 == sx12(p12), "R5 data 12b", q12, sx12(p12));
    end
    p14 = a; p12 = b; exp_first = 1'b0;
  endtask

  initial begin
    int blen;
    total = 0; bad = 0;
    void'($urandom(32'h1403));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; clr = 1'b0;
    w14 = '0; w12 = '0; exp_first = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !trg && !sck && !v14, "R1 reset state", {busy, trg, sck, v14}, 0);

    frame(14'h2000, 12'h800, 1'b0);
    frame(14'h1FFF, 12'h7FF, 1'b0);
    frame(14'h3FFF, 12'hFFF, 1'b0);
    frame(14'h0000, 12'h000, 1'b0);
    frame(14'h2AAA, 12'h555, 1'b0);
    for (int i = 0; i < 16; i++)
      frame(14'($urandom), 12'($urandom), 1'b0);
    frame(14'($urandom), 12'($urandom), 1'b1);
    frame(14'($urandom), 12'($urandom), 1'b0);

    // R7: light power-down
    clear_mon();
    issue(2'b01, blen);
    chk(t14 == 2, "R7 nap pulses", t14, 2);
    chk(r14 == 0, "R7 no sclk in nap", r14, 0);
    // R9: commands ignored while down
    clear_mon();
    issue(2'b00, blen);
    issue(2'b10, blen);
    repeat (10) @(negedge clk);
    chk(t14 == 0 && r14 == 0 && !busy, "R9 ignored while down", t14 + r14, 0);
    // R10: wake from light power-down
    clear_mon();
    issue(2'b11, blen);
    chk(r14 == 1, "R10 wake pulse", r14, 1);
    chk(blen <= 2 * HALF + 1, "R10 nap wake time", blen, 2 * HALF + 1);
    exp_first = 1'b1;
    frame(14'($urandom), 12'($urandom), 1'b0);
    frame(14'($urandom), 12'($urandom), 1'b0);

    // R8: deep power-down
    clear_mon();
    issue(2'b10, blen);
    chk(t14 == 4, "R8 sleep pulses", t14, 4);
    chk(r14 == 0, "R8 no sclk in sleep", r14, 0);
    clear_mon();
    issue(2'b11, blen);
    chk(r14 == 1, "R10 wake pulse sleep", r14, 1);
    chk(blen >= SETTLE, "R10 settle wait", blen, SETTLE);
    exp_first = 1'b1;
    frame(14'($urandom), 12'($urandom), 1'b0);
    frame(14'($urandom), 12'($urandom), 1'b0);
    frame(14'h2001, 12'h801, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule